// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This block is the hazard unit of a five-stage, in-order integer pipeline. It looks at the two source register numbers of the instruction in the execute stage. It compares each one with the destination register numbers held by the two younger-result pipeline registers: execute/memory and memory/writeback. For each ALU operand it returns a 2-bit select that steers the operand mux toward the freshest copy of the value.

The same unit also catches the one dependence that forwarding cannot cover. This is a load in the decode/execute register whose destination is read by the instruction right behind it, in the fetch/decode register. In that case it raises a hold on the program counter, a hold on the fetch/decode register and a bubble request for the decode/execute register, all for that one cycle. Once the bubble has passed, the loaded value arrives through the memory/writeback forwarding path.

Every output is a pure combinational function of the current pipeline-register fields. Register zero is hard-wired and is never forwarded from or stalled on.

Top module: `hz_forward_stall_unit`

## Requirements
- R1: When neither later stage produces the register an operand reads, that operand's select is 2'b00 (register-file value), and the select value 2'b11 never appears.
- R2: When the execute/memory stage has its write flag set, a nonzero destination, and a destination equal to the operand's source, the select is 2'b01.
- R3: When only the memory/writeback stage qualifies (write flag set, nonzero destination equal to the source), the select is 2'b10. This includes a load result arriving there after a stall.
- R4: When both later stages qualify for the same source, the select is 2'b01 (the newer result).
- R5: A stage whose write flag is clear, or whose destination is register zero, is never a forwarding source; the select falls back to the other stage or to 2'b00.
- R6: Operand A (select `fwd_sel_a`) is decided only from `ex_src_a`, and operand B (`fwd_sel_b`) only from `ex_src_b`, each independently of the other.
- R7: When the decode/execute register holds a load (load flag and write flag set, nonzero destination) whose destination equals a used source of the fetch/decode instruction, `pc_hold`, `ifid_hold` and `idex_bubble` are all 1.
- R8: No stall is raised for a source field whose use flag is 0, for a non-load producer, or for a load to register zero.
- R9: `pc_hold`, `ifid_hold` and `idex_bubble` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register of the execute-stage instruction |
| ex_src_b | input | 5 | Second source register of the execute-stage instruction |
| exm_wr | input | 1 | Execute/memory instruction writes a register |
| exm_dst | input | 5 | Execute/memory destination register |
| mwb_wr | input | 1 | Memory/writeback instruction writes a register |
| mwb_dst | input | 5 | Memory/writeback destination register |
| idex_load | input | 1 | Decode/execute instruction is a load |
| idex_wr | input | 1 | Decode/execute instruction writes a register |
| idex_dst | input | 5 | Decode/execute destination register |
| ifid_src_a | input | 5 | First source field of the fetch/decode instruction |
| ifid_src_b | input | 5 | Second source field of the fetch/decode instruction |
| ifid_use_a | input | 1 | Fetch/decode instruction reads its first source |
| ifid_use_b | input | 1 | Fetch/decode instruction reads its second source |
| fwd_sel_a | output | 2 | Operand A select: 00 register file, 01 execute/memory, 10 memory/writeback |
| fwd_sel_b | output | 2 | Operand B select, same encoding |
| pc_hold | output | 1 | Freeze the program counter |
| ifid_hold | output | 1 | Freeze the fetch/decode register |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |

## Verification
The forwarding selects are tried with these patterns:
- no match, which shows the register-file default;
- a single match in each stage, which separates code 01 from code 10;
- a match in both stages, which shows that the newer result wins;
- a cleared write flag and a register-zero destination, which show that a stage is skipped;
- crossed matches on the two operands, which show that each select follows only its own source field.

The stall detector is tried with these patterns:
- a load hit on either source field;
- a hit on a field whose use flag is off;
- a non-load producer;
- a load to register zero.

Together these separate a real load-use hazard from each kind of false stall.

// File: rtl/hz_pkg.sv
package hz_pkg;
    parameter int REG_W   = 5;
    parameter int N_OPND  = 2;

    typedef logic [REG_W-1:0] regnum_t;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_EXM = 2'b01,
        FWD_MWB = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic    wr;
        regnum_t dst;
    } producer_t;
endpackage

// File: rtl/hz_operand_sel.sv
module hz_operand_sel
    import hz_pkg::*;
(
    input  regnum_t   src,
    input  producer_t exm,
    input  producer_t mwb,
    output fwd_sel_e  sel
);
    logic exm_hit_d;
    logic mwb_hit_d;

    always_comb begin
        exm_hit_d = exm.wr && (exm.dst != '0) && (exm.dst == src);
        mwb_hit_d = mwb.wr && (mwb.dst != '0) && (mwb.dst == src);
        if (exm_hit_d)
            sel = FWD_EXM;
        else if (mwb_hit_d)
            sel = FWD_MWB;
        else
            sel = FWD_RF;
    end

    always_comb begin
        if (!$isunknown({src, exm, mwb})) begin
            a_r1_no_code3: assert (sel != 2'b11);
            if (sel == FWD_EXM) begin
                a_r2_exm_source: assert (exm.wr && exm.dst == src);
            end
            if (sel == FWD_MWB) begin
                a_r3_mwb_source: assert (mwb.wr && mwb.dst == src);
            end
            if (sel != FWD_RF) begin
                a_r5_never_zero: assert (src != '0);
            end
        end
    end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
    import hz_pkg::*;
(
    input  logic                  load,
    input  producer_t             prod,
    input  regnum_t [N_OPND-1:0]  src,
    input  logic    [N_OPND-1:0]  use_src,
    output logic                  stall
);
    logic [N_OPND-1:0] field_hit_d;
    logic              load_live_d;

    assign load_live_d = load && prod.wr && (prod.dst != '0);

    for (genvar g = 0; g < N_OPND; g++) begin : g_field
        assign field_hit_d[g] = use_src[g] && (src[g] == prod.dst);
    end

    always_comb begin
        stall = load_live_d && (|field_hit_d);
    end

    always_comb begin
        if (!$isunknown({load, prod, src, use_src})) begin
            if (stall) begin
                a_r8_load_only: assert (load && prod.dst != '0);
            end
            if (use_src == '0) begin
                a_r8_unused_fields: assert (!stall);
            end
        end
    end
endmodule

// File: rtl/hz_forward_stall_unit.sv
module hz_forward_stall_unit
    import hz_pkg::*;
(
    input  logic [REG_W-1:0] ex_src_a,
    input  logic [REG_W-1:0] ex_src_b,
    input  logic             exm_wr,
    input  logic [REG_W-1:0] exm_dst,
    input  logic             mwb_wr,
    input  logic [REG_W-1:0] mwb_dst,
    input  logic             idex_load,
    input  logic             idex_wr,
    input  logic [REG_W-1:0] idex_dst,
    input  logic [REG_W-1:0] ifid_src_a,
    input  logic [REG_W-1:0] ifid_src_b,
    input  logic             ifid_use_a,
    input  logic             ifid_use_b,
    output logic [1:0]       fwd_sel_a,
    output logic [1:0]       fwd_sel_b,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble
);
    producer_t                 exm_q;
    producer_t                 mwb_q;
    producer_t                 idex_q;
    regnum_t   [N_OPND-1:0]    ex_src_q;
    regnum_t   [N_OPND-1:0]    id_src_q;
    logic      [N_OPND-1:0]    id_use_q;
    fwd_sel_e  [N_OPND-1:0]    sel_d;
    logic                      stall_d;

    always_comb begin
        exm_q       = '{wr: exm_wr,  dst: exm_dst};
        mwb_q       = '{wr: mwb_wr,  dst: mwb_dst};
        idex_q      = '{wr: idex_wr, dst: idex_dst};
        ex_src_q[0] = ex_src_a;
        ex_src_q[1] = ex_src_b;
        id_src_q[0] = ifid_src_a;
        id_src_q[1] = ifid_src_b;
        id_use_q    = {ifid_use_b, ifid_use_a};
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        hz_operand_sel u_sel (
            .src (ex_src_q[g]),
            .exm (exm_q),
            .mwb (mwb_q),
            .sel (sel_d[g])
        );
    end

    hz_load_use u_lu (
        .load    (idex_load),
        .prod    (idex_q),
        .src     (id_src_q),
        .use_src (id_use_q),
        .stall   (stall_d)
    );

    always_comb begin
        fwd_sel_a   = sel_d[0];
        fwd_sel_b   = sel_d[1];
        pc_hold     = stall_d;
        ifid_hold   = stall_d;
        idex_bubble = stall_d;
    end

    always_comb begin
        if (!$isunknown({idex_load, idex_wr, idex_dst, ifid_src_a, ifid_src_b,
                         ifid_use_a, ifid_use_b})) begin
            if (stall_d) begin
                a_r7_stall_has_match: assert (
                    (ifid_use_a && ifid_src_a == idex_dst) ||
                    (ifid_use_b && ifid_src_b == idex_dst));
            end
        end
    end
endmodule

// File: tb/sim_hz_forward_stall_unit.sv
module sim_hz_forward_stall_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [4:0] ex_src_a, ex_src_b, exm_dst, mwb_dst, idex_dst, ifid_src_a, ifid_src_b;
    logic       exm_wr, mwb_wr, idex_load, idex_wr, ifid_use_a, ifid_use_b;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic       pc_hold, ifid_hold, idex_bubble;

    hz_forward_stall_unit u0 (.*);

    typedef struct {
        logic [1:0] ea;
        logic [1:0] eb;
        logic       es;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic drive(
        input logic [4:0] sa, input logic [4:0] sb,
        input logic ew, input logic [4:0] ed,
        input logic mw, input logic [4:0] md,
        input logic ld, input logic iw, input logic [4:0] idd,
        input logic [4:0] fa, input logic [4:0] fb, input logic ua, input logic ub,
        input logic [1:0] ea, input logic [1:0] eb, input logic es, input string tag);
        exp_t e;
        @(posedge clk);
        ex_src_a = sa; ex_src_b = sb;
        exm_wr = ew; exm_dst = ed; mwb_wr = mw; mwb_dst = md;
        idex_load = ld; idex_wr = iw; idex_dst = idd;
        ifid_src_a = fa; ifid_src_b = fb; ifid_use_a = ua; ifid_use_b = ub;
        e.ea = ea; e.eb = eb; e.es = es; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (!rst && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "fwd_sel_a", int'(fwd_sel_a), int'(e.ea));
                chk(e.tag, "fwd_sel_b", int'(fwd_sel_b), int'(e.eb));
                chk(e.tag, "pc_hold", int'(pc_hold), int'(e.es));
                chk(e.tag, "ifid_hold (R9)", int'(ifid_hold), int'(e.es));
                chk(e.tag, "idex_bubble (R9)", int'(idex_bubble), int'(e.es));
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        {ex_src_a, ex_src_b, exm_dst, mwb_dst, idex_dst, ifid_src_a, ifid_src_b} = '0;
        {exm_wr, mwb_wr, idex_load, idex_wr, ifid_use_a, ifid_use_b} = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R1 reset-state inputs: all zero
        drive(0,0, 0,0, 0,0, 0,0,0, 0,0,0,0, 2'b00,2'b00,0, "R1 reset");
        // R1 no match anywhere
        drive(3,4, 1,5, 1,6, 0,1,9, 1,2,1,1, 2'b00,2'b00,0, "R1 nomatch");
        // R2 execute/memory match on A
        drive(3,4, 1,3, 1,6, 0,0,0, 0,0,0,0, 2'b01,2'b00,0, "R2 exm_a");
        // R3 memory/writeback match on B
        drive(3,4, 1,5, 1,4, 0,0,0, 0,0,0,0, 2'b00,2'b10,0, "R3 mwb_b");
        // R4 both stages match, both operands
        drive(7,7, 1,7, 1,7, 0,0,0, 0,0,0,0, 2'b01,2'b01,0, "R4 newer_wins");
        // R5 destination zero ignored
        drive(0,0, 1,0, 1,0, 0,0,0, 0,0,0,0, 2'b00,2'b00,0, "R5 dst_zero");
        // R5 exm write clear falls back to mwb
        drive(3,3, 0,3, 1,3, 0,0,0, 0,0,0,0, 2'b10,2'b10,0, "R5 exm_nowrite");
        // R5 both write flags clear
        drive(3,4, 0,3, 0,4, 0,0,0, 0,0,0,0, 2'b00,2'b00,0, "R5 no_writes");
        // R6 crossed matches
        drive(9,12, 1,12, 1,9, 0,0,0, 0,0,0,0, 2'b10,2'b01,0, "R6 crossed");
        // R7 load hit on first source
        drive(1,2, 0,0, 0,0, 1,1,8, 8,3,1,1, 2'b00,2'b00,1, "R7 load_a");
        // R7 load hit on second source
        drive(1,2, 0,0, 0,0, 1,1,8, 3,8,1,1, 2'b00,2'b00,1, "R7 load_b");
        // R8 matching field unused
        drive(1,2, 0,0, 0,0, 1,1,8, 8,2,0,1, 2'b00,2'b00,0, "R8 unused_field");
        // R8 non-load producer
        drive(1,2, 0,0, 0,0, 0,1,8, 8,8,1,1, 2'b00,2'b00,0, "R8 not_load");
        // R8 load to register zero
        drive(1,2, 0,0, 0,0, 1,1,0, 0,0,1,1, 2'b00,2'b00,0, "R8 load_r0");
        // R3 after bubble: load result in memory/writeback
        drive(8,5, 0,0, 1,8, 0,0,0, 0,0,0,0, 2'b10,2'b00,0, "R3 post_stall");
        // R7 stall together with forwarding
        drive(6,11, 1,6, 1,11, 1,1,14, 2,14,0,1, 2'b01,2'b10,1, "R7 stall_fwd");
        repeat (3) @(posedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule